// File: doc/BRIEF.md
# Dual-Clock Up/Down Counter

This block is a reversible binary counter steered by two separate count pins instead of a direction select. A rising edge on the increment pin adds one, provided the decrement pin is high. A rising edge on the decrement pin subtracts one, provided the increment pin is high. An active-low preset copies a parallel data word into the count, and an active-high clear forces the count to zero. The preset and clear win over any counting.

All inputs are treated as asynchronous. They pass through a chain of synchronizer flops to the single system clock. Count edges are found inside the block as a 0-to-1 change of the synchronized pin level, so every count bit changes on the same clock edge.

Two active-low flags let stages chain without glue logic. The carry flag goes low while the count is at its maximum and the synchronized increment pin is low. The borrow flag goes low while the count is zero and the synchronized decrement pin is low. Wiring carry to the next stage's increment pin and borrow to its decrement pin builds a wider counter.

Top module: `updown_dual_counter`

## Requirements
- R1: While rst_n is low, and right after it is released with all pins idle (both count pins high, preset_n_i high, clear_i low), count_o is 0, carry_n_o is 1 and borrow_n_o is 1.
- R2: A rising edge on the synchronized cnt_up_i while the synchronized cnt_dn_i is high adds one to count_o. All bits update on one clock edge, and the maximum value 2^WIDTH-1 wraps to 0.
- R3: A rising edge on the synchronized cnt_dn_i while the synchronized cnt_up_i is high subtracts one from count_o, and 0 wraps to 2^WIDTH-1.
- R4: A rising edge on one count pin while the other count pin is low leaves count_o unchanged.
- R5: While the synchronized preset_n_i is low, count_o follows the synchronized data_i on every clock, and count-pin edges have no effect.
- R6: While the synchronized clear_i is high, count_o is 0, whatever the preset, data and count pins do.
- R7: borrow_n_o is 0 exactly when count_o is 0 and the synchronized cnt_dn_i is 0; otherwise it is 1.
- R8: carry_n_o is 0 exactly when count_o is 2^WIDTH-1 and the synchronized cnt_up_i is 0; otherwise it is 1.
- R9: Every input passes through SYNC_STAGES flops. A count pin change first alters count_o on the (SYNC_STAGES+1)-th rising clock edge after it is applied.
- R10: Two instances with the low stage's carry_n_o driving the high stage's cnt_up_i, and its borrow_n_o driving the high stage's cnt_dn_i, count as one 2*WIDTH-bit counter. This holds for up counts, down counts and wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_up_i | input | 1 | Increment pin, counts on its rising edge |
| cnt_dn_i | input | 1 | Decrement pin, counts on its rising edge |
| preset_n_i | input | 1 | Active-low parallel preset |
| clear_i | input | 1 | Active-high clear |
| data_i | input | WIDTH | Preset value |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low carry flag for cascading |
| borrow_n_o | output | 1 | Active-low borrow flag for cascading |

## Verification
The bench builds two instances with WIDTH = 4 and SYNC_STAGES = 2 and chains them into an 8-bit counter. With 4-bit stages, a few dozen pulses cross the nibble boundary in both directions and wrap the full 8-bit range. The 2-stage synchronizer keeps the three-edge latency short enough to check cycle by cycle. Each stage is modelled from its own pin history, and the high stage's pins come from the modelled low-stage flags. Because of this, carry and borrow timing across the cascade is checked on every clock, along with preset, clear and ignored-edge cases.

// File: rtl/udc_pkg.sv
package udc_pkg;

  // Operation applied to the count register in one system clock cycle.
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4
  } udc_op_e;

endpackage

// File: rtl/udc_sync.sv
module udc_sync #(
  parameter int              WIDTH   = 8,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= RST_VAL;
      end else begin
        stage_q[g] <= stage_d;
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/udc_ctrl.sv
module udc_ctrl
  import udc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    up_s,
  input  logic    dn_s,
  input  logic    ld_n_s,
  input  logic    clr_s,
  output udc_op_e op_o
);

  logic up_prev_q, dn_prev_q;
  logic up_rise, dn_rise;

  assign up_rise = up_s & ~up_prev_q;
  assign dn_rise = dn_s & ~dn_prev_q;

  // Priority: clear, then preset, then counting.
  always_comb begin
    op_o = OP_HOLD;
    if (clr_s) begin
      op_o = OP_CLEAR;
    end else if (!ld_n_s) begin
      op_o = OP_LOAD;
    end else if (up_rise && dn_s) begin
      op_o = OP_INC;
    end else if (dn_rise && up_s) begin
      op_o = OP_DEC;
    end
  end

  // Idle level of both count pins is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_prev_q <= 1'b1;
      dn_prev_q <= 1'b1;
    end else begin
      up_prev_q <= up_s;
      dn_prev_q <= dn_s;
    end
  end

endmodule

// File: rtl/udc_core.sv
module udc_core
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  udc_op_e          op_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o
);

  logic [WIDTH-1:0] count_q, count_d;
  logic             count_en;

  always_comb begin
    count_d = count_q;
    unique case (op_i)
      OP_CLEAR: count_d = '0;
      OP_LOAD:  count_d = data_i;
      OP_INC:   count_d = count_q + WIDTH'(1);
      OP_DEC:   count_d = count_q - WIDTH'(1);
      default:  count_d = count_q;
    endcase
  end

  assign count_en = (op_i != OP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/udc_flags.sv
module udc_flags #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             up_s,
  input  logic             dn_s,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  assign carry_n_o  = ~((count_i == CNT_MAX) & ~up_s);
  assign borrow_n_o = ~((count_i == '0) & ~dn_s);

endmodule

// File: rtl/updown_dual_counter.sv
module updown_dual_counter
  import udc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_up_i,
  input  logic             cnt_dn_i,
  input  logic             preset_n_i,
  input  logic             clear_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  localparam int               BUS_W    = WIDTH + 4;
  localparam logic [BUS_W-1:0] BUS_IDLE = {1'b1, 1'b1, 1'b1, 1'b0, {WIDTH{1'b0}}};

  logic [BUS_W-1:0] pin_bus, sync_bus;
  logic             up_s, dn_s, ld_n_s, clr_s;
  logic [WIDTH-1:0] dat_s;
  udc_op_e          op;

  assign pin_bus = {cnt_up_i, cnt_dn_i, preset_n_i, clear_i, data_i};

  udc_sync #(
    .WIDTH  (BUS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(BUS_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(pin_bus),
    .sync_o (sync_bus)
  );

  assign {up_s, dn_s, ld_n_s, clr_s, dat_s} = sync_bus;

  udc_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .up_s  (up_s),
    .dn_s  (dn_s),
    .ld_n_s(ld_n_s),
    .clr_s (clr_s),
    .op_o  (op)
  );

  udc_core #(.WIDTH(WIDTH)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op),
    .data_i (dat_s),
    .count_o(count_o)
  );

  udc_flags #(.WIDTH(WIDTH)) u_flags (
    .count_i   (count_o),
    .up_s      (up_s),
    .dn_s      (dn_s),
    .carry_n_o (carry_n_o),
    .borrow_n_o(borrow_n_o)
  );

endmodule

// File: rtl/udc_checker.sv
module udc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_s,
  input logic             dn_s,
  input logic             ld_n_s,
  input logic             clr_s,
  input logic [WIDTH-1:0] dat_s,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_n_o,
  input logic             borrow_n_o
);

  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && ld_n_s && dn_s && up_s && !$past(up_s))
    |=> (count_o == WIDTH'($past(count_o) + WIDTH'(1))));

  a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && ld_n_s && up_s && $past(up_s) && dn_s && !$past(dn_s))
    |=> (count_o == WIDTH'($past(count_o) - WIDTH'(1))));

  a_r4_no_stray_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && ld_n_s && !(up_s && !$past(up_s) && dn_s) && !(dn_s && !$past(dn_s) && up_s))
    |=> $stable(count_o));

  a_r5_preset_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && !ld_n_s) |=> (count_o == $past(dat_s)));

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (count_o == '0));

  a_r7_borrow_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != '0) |-> borrow_n_o);

  a_r8_carry_only_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != CNT_MAX) |-> carry_n_o);

endmodule

bind updown_dual_counter udc_checker #(.WIDTH(WIDTH)) u_udc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .up_s      (up_s),
  .dn_s      (dn_s),
  .ld_n_s    (ld_n_s),
  .clr_s     (clr_s),
  .dat_s     (dat_s),
  .count_o   (count_o),
  .carry_n_o (carry_n_o),
  .borrow_n_o(borrow_n_o)
);

// File: tb/updown_dual_counter_test.sv
module updown_dual_counter_test;

  localparam int W  = 4;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_pin = 1'b1, dn_pin = 1'b1, preset_n = 1'b1, clr_pin = 1'b0;
  logic [2*W-1:0] data_pin = '0;

  logic [W-1:0] cnt_lo, cnt_hi;
  logic carry_lo, borrow_lo, carry_hi, borrow_hi;

  always #4 clk = ~clk;

  updown_dual_counter #(.WIDTH(W), .SYNC_STAGES(SS)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_up_i(up_pin), .cnt_dn_i(dn_pin),
    .preset_n_i(preset_n), .clear_i(clr_pin), .data_i(data_pin[W-1:0]),
    .count_o(cnt_lo), .carry_n_o(carry_lo), .borrow_n_o(borrow_lo));

  updown_dual_counter #(.WIDTH(W), .SYNC_STAGES(SS)) uut_hi (
    .clk(clk), .rst_n(rst_n), .cnt_up_i(carry_lo), .cnt_dn_i(borrow_lo),
    .preset_n_i(preset_n), .clear_i(clr_pin), .data_i(data_pin[2*W-1:W]),
    .count_o(cnt_hi), .carry_n_o(carry_hi), .borrow_n_o(borrow_hi));

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";

  // Reference model: per-stage pin history sampled at each rising edge.
  bit       h_up [2][8], h_dn [2][8], h_ld [2][8], h_clr [2][8];
  bit [W-1:0] h_d [2][8];
  bit [W-1:0] m_cnt [2];
  bit       m_carry [2], m_borrow [2];

  always @(posedge clk) begin
    bit up2, dn2;
    up2 = m_carry[0];
    dn2 = m_borrow[0];
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 8; k++) begin
          h_up[s][k] = 1'b1; h_dn[s][k] = 1'b1; h_ld[s][k] = 1'b1;
          h_clr[s][k] = 1'b0; h_d[s][k] = '0;
        end
        m_cnt[s] = '0; m_carry[s] = 1'b1; m_borrow[s] = 1'b1;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 7; k > 0; k--) begin
          h_up[s][k] = h_up[s][k-1]; h_dn[s][k] = h_dn[s][k-1];
          h_ld[s][k] = h_ld[s][k-1]; h_clr[s][k] = h_clr[s][k-1];
          h_d[s][k] = h_d[s][k-1];
        end
      end
      h_up[0][0] = up_pin; h_dn[0][0] = dn_pin; h_ld[0][0] = preset_n;
      h_clr[0][0] = clr_pin; h_d[0][0] = data_pin[W-1:0];
      h_up[1][0] = up2; h_dn[1][0] = dn2; h_ld[1][0] = preset_n;
      h_clr[1][0] = clr_pin; h_d[1][0] = data_pin[2*W-1:W];
      for (int s = 0; s < 2; s++) begin
        if (h_clr[s][SS]) m_cnt[s] = '0;
        else if (!h_ld[s][SS]) m_cnt[s] = h_d[s][SS];
        else if (h_up[s][SS] && !h_up[s][SS+1] && h_dn[s][SS]) m_cnt[s] = m_cnt[s] + 1'b1;
        else if (h_dn[s][SS] && !h_dn[s][SS+1] && h_up[s][SS]) m_cnt[s] = m_cnt[s] - 1'b1;
        m_carry[s]  = !(m_cnt[s] == {W{1'b1}} && !h_up[s][SS-1]);
        m_borrow[s] = !(m_cnt[s] == '0 && !h_dn[s][SS-1]);
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    check(cur_req, "low count",  cnt_lo,    m_cnt[0]);
    check(cur_req, "high count", cnt_hi,    m_cnt[1]);
    check("R8", "low carry",     carry_lo,  m_carry[0]);
    check("R8", "high carry",    carry_hi,  m_carry[1]);
    check("R7", "low borrow",    borrow_lo, m_borrow[0]);
    check("R7", "high borrow",   borrow_hi, m_borrow[1]);
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up(int n);
    for (int i = 0; i < n; i++) begin
      up_pin = 1'b0; wait_n(4);
      up_pin = 1'b1; wait_n(4);
    end
    wait_n(8);
  endtask

  task automatic pulse_dn(int n);
    for (int i = 0; i < n; i++) begin
      dn_pin = 1'b0; wait_n(4);
      dn_pin = 1'b1; wait_n(4);
    end
    wait_n(8);
  endtask

  function automatic int wide();
    return {cnt_hi, cnt_lo};
  endfunction

  task automatic run_all();
    // R1: reset state
    wait_n(5);
    check("R1", "count in reset", wide(), 0);
    check("R1", "carry in reset", carry_lo, 1);
    check("R1", "borrow in reset", borrow_lo, 1);
    rst_n = 1'b1;
    wait_n(4);
    check("R1", "count after reset", wide(), 0);

    // R9: latency of a single up edge
    cur_req = "R9";
    up_pin = 1'b0; wait_n(5);
    up_pin = 1'b1;
    wait_n(1); check("R9", "count after 1 edge", cnt_lo, 0);
    wait_n(1); check("R9", "count after 2 edges", cnt_lo, 0);
    wait_n(1); check("R9", "count after 3 edges", cnt_lo, 1);
    wait_n(6);

    // R2 / R10: up across the nibble boundary
    cur_req = "R2";
    pulse_up(19);
    check("R2", "low nibble after up sweep", cnt_lo, 4);
    check("R10", "8-bit after up sweep", wide(), 20);

    // R3 / R10: down through zero
    cur_req = "R3";
    pulse_dn(25);
    check("R3", "low nibble after down sweep", cnt_lo, 11);
    check("R10", "8-bit after down sweep", wide(), 251);

    // R4: edges while the other pin is low are ignored; release counts once
    cur_req = "R4";
    dn_pin = 1'b0; wait_n(4);
    pulse_up(2);
    check("R4", "up edges with down low", wide(), 251);
    dn_pin = 1'b1; wait_n(10);
    check("R4", "only the release edge counts", wide(), 250);
    up_pin = 1'b0; wait_n(4);
    pulse_dn(2);
    check("R4", "down edges with up low", wide(), 250);
    up_pin = 1'b1; wait_n(10);
    check("R4", "only the release edge counts", wide(), 251);

    // R5: preset follows data continuously and blocks counting
    cur_req = "R5";
    data_pin = 8'h3C; preset_n = 1'b0; wait_n(5);
    pulse_up(2);
    check("R5", "preset holds during up edges", wide(), 8'h3C);
    data_pin = 8'h5A; wait_n(5);
    check("R5", "preset tracks new data", wide(), 8'h5A);
    preset_n = 1'b1; wait_n(5);
    pulse_up(7);
    check("R10", "count on from preset", wide(), 8'h61);

    // R6: clear overrides preset and counting
    cur_req = "R6";
    data_pin = 8'h77; preset_n = 1'b0; clr_pin = 1'b1; wait_n(5);
    check("R6", "clear beats preset", wide(), 0);
    pulse_up(1);
    check("R6", "clear beats counting", wide(), 0);
    clr_pin = 1'b0; wait_n(5);
    check("R5", "preset after clear released", wide(), 8'h77);

    // R2 / R10: full-width wrap upward
    cur_req = "R2";
    data_pin = 8'hFE; wait_n(5);
    preset_n = 1'b1; wait_n(5);
    pulse_up(3);
    check("R2", "wrap past maximum", wide(), 1);

    // R3 / R10: full-width wrap downward
    cur_req = "R6";
    clr_pin = 1'b1; wait_n(5);
    clr_pin = 1'b0; wait_n(5);
    check("R6", "clear to zero", wide(), 0);
    cur_req = "R3";
    pulse_dn(1);
    check("R3", "wrap below zero", wide(), 255);
    check("R10", "high stage wrapped", cnt_hi, 15);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL %s watchdog: actual=timeout expected=completion", cur_req);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule